// File: doc/BRIEF.md
# USB PHY Control Register Bank with Bit-Modify Aliases

This block holds the control and status words of a USB PHY behind a plain 32-bit register port. Software reaches each writable word at its plain address and at three neighbouring alias addresses. The aliases OR bits into the word, AND them out, or XOR them, so a driver can change single fields without a read-modify-write sequence. Reading an alias returns the word it modifies.

A self-clearing request bit in the control word starts a soft reset. The soft reset reloads the power-down, transmit, receive and control words and leaves the others as they are. The asynchronous hardware reset loads all nine words. Read data comes from a register one cycle after the read strobe.

Top module: `phy_csr_bank`

## Requirements
- R1: After the hardware reset, the word at each group reads as follows. Power-down (group 0) is 0x001E1C00, transmit (group 1) is 0x10060607, receive (group 2) is 0x00000000 and control (group 3) is 0xC0200000. Status (group 4) is 0x00000000, debug (group 5) is 0x7F180000, debug-zero-status (group 6) is 0x00000000, second debug (group 7) is 0x00001000 and version (group 8) is 0x04020000. The read data output is zero.
- R2: The word index is the byte address shifted right by 2. Group g occupies word indices 4g to 4g+3: the plain slot at 4g, the OR alias at 4g+1, the clear alias at 4g+2 and the XOR alias at 4g+3. A write to the plain slot of power-down, transmit, receive, control, status, debug or second debug stores the write data.
- R3: A write to the OR alias of an aliased word ORs the write data into that word. The aliased words are groups 0, 1, 2, 3, 5 and 7.
- R4: A write to the clear alias of an aliased word clears the bits that are 1 in the write data.
- R5: A write to the XOR alias of an aliased word inverts the bits that are 1 in the write data.
- R6: A read of any alias of an aliased word returns that word. A read of the alias slots of groups 4, 6 and 8 returns zero. A read of a group above 8 or of a byte address with nonzero low two bits also returns zero.
- R7: A write to the control plain slot or the control OR alias with bit 31 of the data set starts a soft reset. The soft reset loads groups 0 to 3 with their R1 values in place of the written value and leaves groups 4 to 8 unchanged.
- R8: A write to the control XOR alias starts a soft reset only when bit 31 of the data is 1 and control bit 31 is 1 after the XOR.
- R9: A write to the control clear alias never starts a soft reset.
- R10: These writes change no word: writes to debug-zero-status and version, writes to the status alias slots, writes to groups above 8, and writes at a byte address with nonzero low two bits.
- R11: Read data appears on the clock edge that samples the read strobe and holds between reads. A read and a write in the same cycle return the value the word had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 12 | Byte address in the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench targets the three soft-reset triggers on the control word. A design that fired the XOR case on the bit before the XOR would reload the transmit word when software clears the request bit. A design that fired on a clear would wipe the power-down settings. It also writes to the alias slots of status and to the read-only words: a decoder that aliased every group would change the status word there, or return it where zero is due. Same-cycle read and write, and the hold of read data between reads, catch a read path that reads after the update or clears when idle. A free-running mix of writes and reads across the whole window is compared against a behavioural model on every clock.

// File: rtl/phy_csr_pkg.sv
package phy_csr_pkg;

   localparam int NREG    = 9;
   localparam int RG_PWR  = 0;
   localparam int RG_TX   = 1;
   localparam int RG_RX   = 2;
   localparam int RG_CTL  = 3;
   localparam int RG_STAT = 4;
   localparam int RG_DBG  = 5;
   localparam int RG_DBG0 = 6;
   localparam int RG_DBG1 = 7;
   localparam int RG_VER  = 8;

   // value loaded by the hardware reset (and by soft reset for groups 0..3)
   function automatic logic [31:0] init_value(int k);
      case (k)
         RG_PWR:  return 32'h001E_1C00;
         RG_TX:   return 32'h1006_0607;
         RG_CTL:  return 32'hC020_0000;
         RG_DBG:  return 32'h7F18_0000;
         RG_DBG1: return 32'h0000_1000;
         RG_VER:  return 32'h0402_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit soft_target(int k);
      return (k <= RG_CTL);
   endfunction

   function automatic bit has_alias(int k);
      return (k <= RG_CTL) || (k == RG_DBG) || (k == RG_DBG1);
   endfunction

   function automatic bit sw_writable(int k);
      return (k != RG_DBG0) && (k != RG_VER) && (k < NREG);
   endfunction

endpackage

// File: rtl/phy_csr_decode.sv
module phy_csr_decode
   import phy_csr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic [NREG-1:0]   wr_base,
   output logic [NREG-1:0]   wr_set,
   output logic [NREG-1:0]   wr_clr,
   output logic [NREG-1:0]   wr_tog,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              rd_hit
);
   localparam int GRP_W = ADDR_W - 4;

   logic [GRP_W-1:0] grp;
   logic [1:0]       slot;
   logic             aligned;
   logic             in_range;

   assign grp      = addr[ADDR_W-1:4];
   assign slot     = addr[3:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = aligned && (grp < GRP_W'(NREG));
   assign rd_idx   = IDX_W'(grp);

   always_comb begin
      rd_hit = 1'b0;
      if (in_range)
         rd_hit = (slot == 2'd0) || has_alias(int'(grp));
   end

   for (genvar k = 0; k < NREG; k++) begin : g_sel
      logic hit;
      assign hit        = wr && in_range && (grp == GRP_W'(k));
      assign wr_base[k] = hit && (slot == 2'd0) && sw_writable(k);
      assign wr_set[k]  = hit && (slot == 2'd1) && has_alias(k);
      assign wr_clr[k]  = hit && (slot == 2'd2) && has_alias(k);
      assign wr_tog[k]  = hit && (slot == 2'd3) && has_alias(k);
   end

endmodule

// File: rtl/phy_csr_cell.sv
module phy_csr_cell #(
   parameter int              DATA_W   = 32,
   parameter logic [DATA_W-1:0] INIT_VAL = '0,
   parameter bit              RELOAD   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_load,
   input  logic              wr_base,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic              wr_tog,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= INIT_VAL;
      else if (RELOAD && soft_load)
         q <= INIT_VAL;
      else if (wr_base)
         q <= wdata;
      else if (wr_set)
         q <= q | wdata;
      else if (wr_clr)
         q <= q & ~wdata;
      else if (wr_tog)
         q <= q ^ wdata;
   end

   // R3
   a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && !(RELOAD && soft_load)) |=> (q == $past(q | wdata)));
   // R4
   a_r4_clr_and: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !(RELOAD && soft_load)) |=> (q == $past(q & ~wdata)));
   // R5
   a_r5_tog_xor: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tog && !(RELOAD && soft_load)) |=> (q == $past(q ^ wdata)));

endmodule

// File: rtl/phy_csr_bank.sv
module phy_csr_bank
   import phy_csr_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int SRST_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int IDX_W = $clog2(NREG);

   if (DATA_W != 32) begin : g_bad_width
      $error("phy_csr_bank: DATA_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("phy_csr_bank: ADDR_W too small for nine groups");
   end
   if (SRST_BIT >= DATA_W) begin : g_bad_bit
      $error("phy_csr_bank: SRST_BIT outside the data word");
   end

   logic [NREG-1:0]   wr_base, wr_set, wr_clr, wr_tog;
   logic [IDX_W-1:0]  rd_idx;
   logic              rd_hit;
   logic [DATA_W-1:0] q [NREG];
   logic              srst;
   logic [DATA_W-1:0] rd_val;

   phy_csr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .wr_base (wr_base),
      .wr_set  (wr_set),
      .wr_clr  (wr_clr),
      .wr_tog  (wr_tog),
      .rd_idx  (rd_idx),
      .rd_hit  (rd_hit)
   );

   // soft reset request: plain or OR write with the bit, or XOR that leaves it at 1
   assign srst = bus_wdata[SRST_BIT] &&
                 (wr_base[RG_CTL] || wr_set[RG_CTL] ||
                  (wr_tog[RG_CTL] && !q[RG_CTL][SRST_BIT]));

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      phy_csr_cell #(
         .DATA_W   (DATA_W),
         .INIT_VAL (DATA_W'(init_value(k))),
         .RELOAD   (soft_target(k))
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_load (srst),
         .wr_base   (wr_base[k]),
         .wr_set    (wr_set[k]),
         .wr_clr    (wr_clr[k]),
         .wr_tog    (wr_tog[k]),
         .wdata     (bus_wdata),
         .q         (q[k])
      );
   end

   always_comb begin
      rd_val = '0;
      if (rd_hit)
         rd_val = q[rd_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_val;
   end

   // R7
   a_r7_soft_reload: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (q[RG_PWR] == DATA_W'(init_value(RG_PWR)) &&
                q[RG_TX]  == DATA_W'(init_value(RG_TX))  &&
                q[RG_CTL] == DATA_W'(init_value(RG_CTL))));
   // R7: words outside the soft-reset set keep their value
   a_r7_dbg_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (srst && !wr_base[RG_DBG]) |=> $stable(q[RG_DBG]));
   // R8
   a_r8_tog_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tog[RG_CTL] && bus_wdata[SRST_BIT] && q[RG_CTL][SRST_BIT])
      |=> !q[RG_CTL][SRST_BIT]);
   // R9
   a_r9_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr[RG_CTL] |=> (q[RG_CTL] == $past(q[RG_CTL] & ~bus_wdata)));
   // R10
   a_r10_ver_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (q[RG_VER] == DATA_W'(init_value(RG_VER))));
   // R11
   a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_phy_csr_bank.sv
module sim_phy_csr_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string cur_req = "R11";

   logic [31:0] m [9];
   logic [31:0] exp_rd = '0;

   always #10 clk = ~clk;

   phy_csr_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] rv(int k);
      logic [31:0] t [9] = '{32'h001E1C00, 32'h10060607, 32'h0, 32'hC0200000,
                             32'h0, 32'h7F180000, 32'h0, 32'h00001000, 32'h04020000};
      return t[k];
   endfunction

   function automatic bit aliased(int k);
      return k == 0 || k == 1 || k == 2 || k == 3 || k == 5 || k == 7;
   endfunction

   function automatic logic [31:0] mread(logic [11:0] a);
      int w = int'(a) / 4;
      int k = w / 4;
      int s = w % 4;
      if (a[1:0] != 2'b00 || k > 8) return 32'h0;
      if (s == 0 || aliased(k)) return m[k];
      return 32'h0;
   endfunction

   task automatic mwrite(logic [11:0] a, logic [31:0] d);
      int w = int'(a) / 4;
      int k = w / 4;
      int s = w % 4;
      bit fire = 1'b0;
      if (a[1:0] != 2'b00 || k > 8) return;
      if (s == 0 && k != 6 && k != 8) m[k] = d;
      else if (s != 0 && aliased(k)) begin
         if (s == 1) m[k] = m[k] | d;
         else if (s == 2) m[k] = m[k] & ~d;
         else m[k] = m[k] ^ d;
      end
      if (k == 3 && d[31]) begin
         if (s == 0 || s == 1) fire = 1'b1;
         if (s == 3 && m[3][31]) fire = 1'b1;
      end
      if (fire) for (int i = 0; i < 4; i++) m[i] = rv(i);
   endtask

   // behavioural reference, updated on each edge from the bus inputs
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 9; i++) m[i] = rv(i);
         exp_rd = '0;
      end else begin
         if (bus_rd) exp_rd = mread(bus_addr);
         if (bus_wr) mwrite(bus_addr, bus_wdata);
      end
   end

   task automatic check(string r, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s: got %08h expected %08h", r, act, expv);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) if (rst_n) check({cur_req, " model"}, bus_rdata, exp_rd);

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd_chk(logic [11:0] a, logic [31:0] e, string r);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      @(negedge clk); bus_rd = 1'b0;
      check(r, bus_rdata, e);
   endtask

   function automatic logic [11:0] ad(int grp, int slot);
      return 12'((grp * 4 + slot) * 4);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hang expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] lcg;
      repeat (3) @(negedge clk);
      check("R1 rdata", bus_rdata, 32'h0);
      rst_n = 1'b1;
      cur_req = "R1";
      for (int k = 0; k < 9; k++) rd_chk(ad(k, 0), rv(k), "R1");

      cur_req = "R2";
      wr(ad(0, 0), 32'h12345678);  rd_chk(ad(0, 0), 32'h12345678, "R2");
      wr(ad(4, 0), 32'h0000A5A5);  rd_chk(ad(4, 0), 32'h0000A5A5, "R2");
      cur_req = "R3";
      wr(ad(0, 1), 32'h0000F000);  rd_chk(ad(0, 0), 32'h1234F678, "R3");
      cur_req = "R4";
      wr(ad(0, 2), 32'h00000678);  rd_chk(ad(0, 0), 32'h1234F000, "R4");
      cur_req = "R5";
      wr(ad(0, 3), 32'hFF00000F);  rd_chk(ad(0, 0), 32'hED34F00F, "R5");
      cur_req = "R6";
      rd_chk(ad(0, 1), 32'hED34F00F, "R6");
      rd_chk(ad(0, 3), 32'hED34F00F, "R6");
      rd_chk(ad(4, 1), 32'h0, "R6");
      rd_chk(ad(8, 2), 32'h0, "R6");
      rd_chk(ad(10, 0), 32'h0, "R6");
      rd_chk(ad(0, 0) + 12'd2, 32'h0, "R6");

      cur_req = "R10";
      wr(ad(8, 0), 32'hFFFFFFFF);  rd_chk(ad(8, 0), 32'h04020000, "R10");
      wr(ad(6, 0), 32'h00000001);  rd_chk(ad(6, 0), 32'h0, "R10");
      wr(ad(4, 1), 32'h000000FF);  rd_chk(ad(4, 0), 32'h0000A5A5, "R10");
      wr(ad(4, 3), 32'h0000FFFF);  rd_chk(ad(4, 0), 32'h0000A5A5, "R10");
      wr(ad(0, 0) + 12'd1, 32'h0); rd_chk(ad(0, 0), 32'hED34F00F, "R10");

      cur_req = "R7";
      wr(ad(5, 0), 32'h00000011);
      wr(ad(3, 0), 32'h80000005);
      rd_chk(ad(3, 0), 32'hC0200000, "R7");
      rd_chk(ad(0, 0), 32'h001E1C00, "R7");
      rd_chk(ad(5, 0), 32'h00000011, "R7");
      rd_chk(ad(4, 0), 32'h0000A5A5, "R7");
      wr(ad(1, 0), 32'h00000005);
      wr(ad(3, 1), 32'h80000000);
      rd_chk(ad(1, 0), 32'h10060607, "R7");

      cur_req = "R8";
      wr(ad(1, 0), 32'h00000005);
      wr(ad(3, 3), 32'h80000000);
      rd_chk(ad(3, 0), 32'h40200000, "R8");
      rd_chk(ad(1, 0), 32'h00000005, "R8");
      wr(ad(3, 3), 32'h80000001);
      rd_chk(ad(3, 0), 32'hC0200000, "R8");
      rd_chk(ad(1, 0), 32'h10060607, "R8");
      wr(ad(1, 0), 32'h00000005);
      wr(ad(3, 3), 32'h00000001);
      rd_chk(ad(3, 0), 32'hC0200001, "R8");
      rd_chk(ad(1, 0), 32'h00000005, "R8");

      cur_req = "R9";
      wr(ad(3, 2), 32'h80000000);
      rd_chk(ad(3, 0), 32'h40200001, "R9");
      rd_chk(ad(1, 0), 32'h00000005, "R9");
      wr(ad(3, 2), 32'hFFFFFFFF);
      rd_chk(ad(3, 0), 32'h0, "R9");

      cur_req = "R11";
      @(negedge clk);
      bus_addr = ad(7, 0); bus_wdata = 32'h0000AAAA; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
      check("R11 old value", bus_rdata, 32'h00001000);
      repeat (3) @(negedge clk);
      check("R11 hold", bus_rdata, 32'h00001000);
      rd_chk(ad(7, 0), 32'h0000AAAA, "R11");

      cur_req = "R2 mix";
      lcg = 32'h1234ABCD;
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         bus_addr  = {lcg[21:16] % 6'd40, 2'b00} | ((lcg[9:8] == 2'b11) ? 12'd1 : 12'd0);
         bus_wdata = {lcg[31], lcg[7:0] ^ lcg[30:23], lcg[22:0]};
         bus_wr    = lcg[5];
         bus_rd    = lcg[3] | ~lcg[5];
      end
      @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
      for (int k = 0; k < 9; k++) rd_chk(ad(k, 0), m[k], "R2 final");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule